// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Redirection Table

This block is the register side of an I/O interrupt controller. It stores a small identification field, a fixed version word and one 64-bit redirection entry per interrupt pin. Software does not address these registers directly. It first writes an index into a select register, then reads or writes a data window, and the access goes to whichever register that index names.

Each 64-bit redirection entry takes two consecutive indices. An even index reaches the low word and an odd index reaches the high word. When a window write lands in the table, the block raises a one-cycle rescan pulse so that the neighbouring service engine can look at the pending interrupts again. The whole table is also presented as a flat bus, so the service engine can read any entry without going through the window.

Top module: `intc_regwin`

## Requirements
- R1: `off_i` == 0x00 addresses the select register and `off_i` == 0x10 addresses the data window. Any other offset reads as 0, and a write to it changes no state.
- R2: A write to the select register stores `wdata_i[7:0]` whatever `size_i` is. A read of the select register returns that index zero-extended to 32 bits, whatever `size_i` is.
- R3: `size_i` gives the access width in bytes. A window access with `size_i` != 4 changes no state, and a read of that kind returns 0.
- R4: A window write at index 0 loads the 4-bit ID from `wdata_i[27:24]`. Reads at index 0 and at index 2 both return the ID in bits [27:24] with every other bit zero. Writes at index 1 and at index 2 are ignored.
- R5: A window read at index 1 returns 0x11 ORed with (NUM_PINS-1) shifted left by 16. With the default of 24 pins this is 0x00170011.
- R6: A window index at or above 0x10 selects entry (index-0x10)>>1. An odd index reaches bits [63:32] of that entry and an even index reaches bits [31:0].
- R7: A write to one half of an entry leaves the other half of that entry, and every other entry, unchanged.
- R8: Indices 3 to 0x0F, and indices past the last entry, read as 0 and ignore writes.
- R9: After reset every entry is 0x0000_0000_0001_0000, that is, only the mask bit (bit 16) is set. The ID and the select index are 0.
- R10: `rescan_o` is high for exactly the one cycle that follows each accepted table write, and is low at all other times.
- R11: `rdata_o` is registered. It carries the result in the cycle after `rd_en_i` and is 0 in the cycle after any cycle without `rd_en_i`. When a read and a write happen in the same cycle, the read returns the value from before the write.
- R12: `tbl_o[64*n +: 64]` holds entry n and shows a write in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| off_i | input | 8 | Low byte of the access address |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| size_i | input | 3 | Access width in bytes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the request |
| rescan_o | output | 1 | One-cycle pulse after an accepted table write |
| tbl_o | output | 64*NUM_PINS | Every redirection entry, entry n at bits [64n+63:64n] |

## Verification
The hardest case to reach from the ports is a partial entry update. Two accesses are needed before a single half can be written: one that moves the select register and one that writes through the window. To show that the untouched half survived, the bench has to set up both halves first. The stimulus therefore writes the high half, then the low half, then rewrites the high half of the same entry. Between those writes it issues rejected writes of the wrong width, and it places a read in the same cycle as a write. The reference model is compared against the whole table bus on every clock, so a half that was clobbered or left stale shows up at once.

// File: rtl/intc_regwin_pkg.sv
package intc_regwin_pkg;
  typedef enum logic [2:0] {
    IDX_NONE,
    IDX_ID,
    IDX_VER,
    IDX_ARB,
    IDX_TBL
  } idx_kind_e;

  localparam int unsigned ENTRY_W = 64;
  localparam int unsigned HALF_W  = 32;
endpackage

// File: rtl/intc_regwin_dec.sv
module intc_regwin_dec
  import intc_regwin_pkg::*;
#(
  parameter int unsigned SEL_W    = 8,
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned TBL_BASE = 16,
  parameter int unsigned ENT_W    = 5
) (
  input  logic [SEL_W-1:0] sel_i,
  output idx_kind_e        kind_o,
  output logic [ENT_W-1:0] ent_o,
  output logic             hi_o
);
  logic [SEL_W-1:0] rel;
  logic [SEL_W-2:0] ent_full;

  assign rel      = sel_i - SEL_W'(TBL_BASE);
  assign ent_full = rel[SEL_W-1:1];
  assign hi_o     = rel[0];
  assign ent_o    = ent_full[ENT_W-1:0];

  always_comb begin
    kind_o = IDX_NONE;
    if (sel_i == SEL_W'(0))      kind_o = IDX_ID;
    else if (sel_i == SEL_W'(1)) kind_o = IDX_VER;
    else if (sel_i == SEL_W'(2)) kind_o = IDX_ARB;
    else if (sel_i >= SEL_W'(TBL_BASE) && ent_full < (SEL_W-1)'(NUM_PINS))
      kind_o = IDX_TBL;
  end
endmodule

// File: rtl/intc_regwin_tbl.sv
module intc_regwin_tbl
  import intc_regwin_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned ENT_W    = 5,
  parameter int unsigned MASK_BIT = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [ENT_W-1:0]             ent_i,
  input  logic                         hi_i,
  input  logic [HALF_W-1:0]            wdata_i,
  output logic [NUM_PINS*ENTRY_W-1:0]  tbl_o
);
  localparam logic [ENTRY_W-1:0] RST_ENTRY = ENTRY_W'(1) << MASK_BIT;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    logic [ENTRY_W-1:0] ent_q;
    logic               hit;

    assign hit = wr_i && (ent_i == ENT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= RST_ENTRY;
      end else if (hit) begin
        if (hi_i) ent_q[ENTRY_W-1:HALF_W] <= wdata_i;
        else      ent_q[HALF_W-1:0]       <= wdata_i;
      end
    end

    assign tbl_o[g*ENTRY_W +: ENTRY_W] = ent_q;
  end
endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
  import intc_regwin_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 24,
  parameter int unsigned SEL_W     = 8,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned ID_LSB    = 24,
  parameter int unsigned VER_CONST = 'h11,
  parameter int unsigned ENT_LSB   = 16,
  parameter int unsigned TBL_BASE  = 'h10,
  parameter int unsigned MASK_BIT  = 16,
  parameter logic [7:0]  SEL_OFS   = 8'h00,
  parameter logic [7:0]  WIN_OFS   = 8'h10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [7:0]                   off_i,
  input  logic                         wr_en_i,
  input  logic                         rd_en_i,
  input  logic [2:0]                   size_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output logic                         rescan_o,
  output logic [NUM_PINS*64-1:0]       tbl_o
);
  localparam int unsigned ENT_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [31:0] VER_WORD = 32'(VER_CONST) | (32'(NUM_PINS - 1) << ENT_LSB);

  logic [SEL_W-1:0] sel_q;
  logic [ID_W-1:0]  id_q;
  logic [31:0]      rdata_q;
  logic             rescan_q;

  idx_kind_e        idx_kind;
  logic [ENT_W-1:0] idx_ent;
  logic             idx_hi;

  logic sel_hit, win_ok, win_wr, tbl_wr;
  logic [31:0] rd_val;

  assign sel_hit = (off_i == SEL_OFS);
  assign win_ok  = (off_i == WIN_OFS) && (size_i == 3'd4);
  assign win_wr  = wr_en_i && win_ok;
  assign tbl_wr  = win_wr && (idx_kind == IDX_TBL);

  intc_regwin_dec #(
    .SEL_W(SEL_W), .NUM_PINS(NUM_PINS), .TBL_BASE(TBL_BASE), .ENT_W(ENT_W)
  ) u_dec (
    .sel_i (sel_q),
    .kind_o(idx_kind),
    .ent_o (idx_ent),
    .hi_o  (idx_hi)
  );

  intc_regwin_tbl #(
    .NUM_PINS(NUM_PINS), .ENT_W(ENT_W), .MASK_BIT(MASK_BIT)
  ) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (tbl_wr),
    .ent_i  (idx_ent),
    .hi_i   (idx_hi),
    .wdata_i(wdata_i),
    .tbl_o  (tbl_o)
  );

  always_comb begin
    rd_val = '0;
    if (sel_hit) begin
      rd_val = 32'(sel_q);
    end else if (win_ok) begin
      unique case (idx_kind)
        IDX_ID, IDX_ARB: rd_val = 32'(id_q) << ID_LSB;
        IDX_VER:         rd_val = VER_WORD;
        IDX_TBL:         rd_val = tbl_o[int'(idx_ent)*64 + (idx_hi ? 32 : 0) +: 32];
        default:         rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      id_q     <= '0;
      rdata_q  <= '0;
      rescan_q <= 1'b0;
    end else begin
      rdata_q  <= rd_en_i ? rd_val : '0;
      rescan_q <= tbl_wr;
      if (wr_en_i && sel_hit) sel_q <= wdata_i[SEL_W-1:0];
      if (win_wr && idx_kind == IDX_ID) id_q <= wdata_i[ID_LSB +: ID_W];
    end
  end

  assign rdata_o  = rdata_q;
  assign rescan_o = rescan_q;
endmodule

// File: rtl/intc_regwin_chk.sv
module intc_regwin_chk
  import intc_regwin_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned ENT_W    = 5,
  parameter logic [7:0]  SEL_OFS  = 8'h00,
  parameter logic [7:0]  WIN_OFS  = 8'h10
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [7:0]             off_i,
  input logic                   wr_en_i,
  input logic                   rd_en_i,
  input logic [2:0]             size_i,
  input logic [31:0]            rdata_o,
  input logic                   rescan_o,
  input logic [NUM_PINS*64-1:0] tbl_o,
  input idx_kind_e              kind_i,
  input logic [ENT_W-1:0]       ent_i,
  input logic                   hi_i
);
  logic             acc_q;
  logic             keep_v;
  logic [ENT_W-1:0] keep_ent;
  logic             keep_hi;
  logic [31:0]      keep_val;
  logic             acc_now;

  assign acc_now = wr_en_i && off_i == WIN_OFS && size_i == 3'd4 && kind_i == IDX_TBL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= 1'b0;
      keep_v   <= 1'b0;
      keep_ent <= '0;
      keep_hi  <= 1'b0;
      keep_val <= '0;
    end else begin
      acc_q    <= acc_now;
      keep_v   <= acc_now;
      keep_ent <= ent_i;
      keep_hi  <= hi_i;
      keep_val <= tbl_o[int'(ent_i)*64 + (hi_i ? 0 : 32) +: 32];
    end
  end

  assert_rescan_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rescan_o == acc_q);

  assert_bad_size_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && off_i == WIN_OFS && size_i != 3'd4) |-> rdata_o == '0);

  assert_bad_size_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && off_i == WIN_OFS && size_i != 3'd4) |-> $stable(tbl_o));

  assert_other_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && off_i != SEL_OFS && off_i != WIN_OFS) |-> rdata_o == '0);

  assert_idle_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rd_en_i) |-> rdata_o == '0);

  assert_half_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_v |-> tbl_o[int'(keep_ent)*64 + (keep_hi ? 0 : 32) +: 32] == keep_val);
endmodule

bind intc_regwin intc_regwin_chk #(
  .NUM_PINS(NUM_PINS), .ENT_W(ENT_W), .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .off_i   (off_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .size_i  (size_i),
  .rdata_o (rdata_o),
  .rescan_o(rescan_o),
  .tbl_o   (tbl_o),
  .kind_i  (idx_kind),
  .ent_i   (idx_ent),
  .hi_i    (idx_hi)
);

// File: tb/intc_regwin_bench.sv
module intc_regwin_bench;
  localparam int NP = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic [7:0]     off;
  logic           wr_en, rd_en;
  logic [2:0]     size;
  logic [31:0]    wdata;
  logic [31:0]    rdata;
  logic           rescan;
  logic [NP*64-1:0] tbl;

  intc_regwin u_intc_regwin (
    .clk_i(clk), .rst_ni(rst_n), .off_i(off), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .rescan_o(rescan), .tbl_o(tbl)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R9";

  logic [63:0] m_tbl [NP];
  logic [3:0]  m_id;
  logic [7:0]  m_sel;
  logic [31:0] m_rd;
  logic        m_rs;

  function automatic logic [31:0] mread(input logic [7:0] o, input logic [2:0] s);
    int idx, e;
    if (o == 8'h00) return {24'd0, m_sel};
    if (o != 8'h10 || s != 3'd4) return 32'd0;
    idx = int'(m_sel);
    if (idx == 0 || idx == 2) return {4'd0, m_id, 24'd0};
    if (idx == 1) return 32'h11 | ((NP - 1) << 16);
    if (idx < 16) return 32'd0;
    e = (idx - 16) / 2;
    if (e >= NP) return 32'd0;
    return (idx % 2 == 1) ? m_tbl[e][63:32] : m_tbl[e][31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_tbl[i] <= 64'h1_0000;
      m_id <= '0; m_sel <= '0; m_rd <= '0; m_rs <= 1'b0;
    end else begin
      int idx, e;
      m_rd <= rd_en ? mread(off, size) : 32'd0;
      m_rs <= 1'b0;
      idx = int'(m_sel);
      if (wr_en && off == 8'h00) m_sel <= wdata[7:0];
      if (wr_en && off == 8'h10 && size == 3'd4) begin
        if (idx == 0) m_id <= wdata[27:24];
        if (idx >= 16 && (idx - 16) / 2 < NP) begin
          e = (idx - 16) / 2;
          if (idx % 2 == 1) m_tbl[e][63:32] <= wdata;
          else              m_tbl[e][31:0]  <= wdata;
          m_rs <= 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NP*64-1:0] exp_tbl;
      for (int i = 0; i < NP; i++) exp_tbl[i*64 +: 64] = m_tbl[i];
      checks += 3;
      if (rdata !== m_rd) begin
        fails++;
        $display("FAIL %s rdata act=%h exp=%h", cur_req, rdata, m_rd);
      end
      if (rescan !== m_rs) begin
        fails++;
        $display("FAIL %s/R10 rescan act=%b exp=%b", cur_req, rescan, m_rs);
      end
      if (tbl !== exp_tbl) begin
        fails++;
        $display("FAIL %s/R12 tbl act=%h exp=%h", cur_req, tbl, exp_tbl);
      end
    end
  end

  task automatic op(input logic w, input logic r, input logic [7:0] o,
                    input logic [2:0] s, input logic [31:0] d);
    wr_en = w; rd_en = r; off = o; size = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic sel_idx(input logic [7:0] i);
    op(1'b1, 1'b0, 8'h00, 3'd4, {24'd0, i});
  endtask

  task automatic win_wr(input logic [31:0] d);
    op(1'b1, 1'b0, 8'h10, 3'd4, d);
  endtask

  task automatic win_rd();
    op(1'b0, 1'b1, 8'h10, 3'd4, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; off = '0; wr_en = 0; rd_en = 0; size = 3'd4; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R9";
    sel_idx(8'h10); win_rd(); sel_idx(8'h3F); win_rd(); sel_idx(8'h00); win_rd();
    op(1'b0, 1'b1, 8'h00, 3'd4, 0);

    cur_req = "R2";
    op(1'b1, 1'b0, 8'h00, 3'd1, 32'hFFFF_FF2A);
    op(1'b0, 1'b1, 8'h00, 3'd1, 0);
    op(1'b0, 1'b1, 8'h00, 3'd2, 0);

    cur_req = "R5";
    sel_idx(8'h01); win_rd();

    cur_req = "R4";
    sel_idx(8'h00); win_wr(32'hA500_00FF); win_rd();
    sel_idx(8'h02); win_rd(); win_wr(32'h0C00_0000); win_rd();
    sel_idx(8'h01); win_wr(32'h0300_0000); win_rd();
    sel_idx(8'h00); win_rd();

    cur_req = "R6";
    sel_idx(8'h10); win_wr(32'h0000_0031); win_rd();
    sel_idx(8'h3F); win_wr(32'hFF00_0000); win_rd();
    sel_idx(8'h3E); win_rd();
    sel_idx(8'h21); win_wr(32'h1234_5678);

    cur_req = "R7";
    sel_idx(8'h1B); win_wr(32'hDEAD_BEEF);
    sel_idx(8'h1A); win_wr(32'h0000_8042); win_rd();
    sel_idx(8'h1B); win_rd(); win_wr(32'h0F00_0000); win_rd();
    sel_idx(8'h1A); win_rd();

    cur_req = "R3";
    op(1'b1, 1'b0, 8'h10, 3'd2, 32'h5555_5555);
    op(1'b1, 1'b0, 8'h10, 3'd1, 32'hAAAA_AAAA);
    op(1'b0, 1'b1, 8'h10, 3'd1, 0);
    op(1'b0, 1'b1, 8'h10, 3'd2, 0);
    sel_idx(8'h00);
    op(1'b1, 1'b0, 8'h10, 3'd1, 32'h0F00_0000);
    win_rd();

    cur_req = "R8";
    sel_idx(8'h08); win_wr(32'hFFFF_FFFF); win_rd();
    sel_idx(8'h0F); win_wr(32'hFFFF_FFFF); win_rd();
    sel_idx(8'h40); win_wr(32'hFFFF_FFFF); win_rd();
    sel_idx(8'hFF); win_wr(32'hFFFF_FFFF); win_rd();

    cur_req = "R1";
    op(1'b1, 1'b0, 8'h04, 3'd4, 32'h0000_0011);
    op(1'b0, 1'b1, 8'h04, 3'd4, 0);
    op(1'b0, 1'b1, 8'h14, 3'd4, 0);
    op(1'b0, 1'b1, 8'h00, 3'd4, 0);

    cur_req = "R11";
    sel_idx(8'h12);
    op(1'b1, 1'b1, 8'h10, 3'd4, 32'h7777_0001);
    win_rd();
    op(1'b0, 1'b0, 8'h10, 3'd4, 0);

    cur_req = "R10";
    sel_idx(8'h14); win_wr(32'h1); win_wr(32'h2); win_wr(32'h3);
    op(1'b0, 1'b0, 8'h00, 3'd4, 0);
    op(1'b0, 1'b0, 8'h00, 3'd4, 0);

    cur_req = "R12";
    for (int i = 0; i < 2 * NP; i++) begin
      sel_idx(8'(16 + i));
      win_wr(32'h100 * i + 32'h5);
    end
    sel_idx(8'h3F); win_rd();
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule